// File: doc/BRIEF.md
# Paged DMA Address Translator

This block turns a device bus address into a system physical address by looking up a table of 64-bit translation entries, one entry per I/O page. Each lookup request carries a bus address and a flag that marks it as a write. The table index is the bus address shifted right by the page shift. The response carries four values: the page-aligned I/O address, the translated page base, a mask that marks the in-page offset bits, and a two-bit permission code taken from the entry. It also raises a violation flag when the direction of the request does not match a one-way entry. Entries are loaded through a simple write port. Page shift and entry count are run-time configuration inputs, sampled when a request is accepted.

A small controller sequences the block through three named states. `ST_CLEAR` sweeps every table entry to zero after reset, one entry per cycle. `ST_IDLE` accepts a request. `ST_RESP` presents the response until it is taken. The named transitions are: T_CLEAR_DONE (`ST_CLEAR` to `ST_IDLE`, after the last entry is zeroed), T_ACCEPT (`ST_IDLE` to `ST_RESP`, on `req_valid`), and T_RELEASE (`ST_RESP` to `ST_IDLE`, on `resp_ready`). The table RAM has a one-cycle synchronous read, so a response is presented one cycle after the request is accepted.

Top module: `tce_xlate`

## Requirements
- R1: After reset, `req_ready` stays low while all DEPTH entries are written to zero, one per cycle. Once that sweep ends, every entry reads as permission 0 with a zero translated base.
- R2: For an in-range lookup with effective shift s, `resp_iova` is the bus address with bits [s-1:0] cleared, and `resp_xaddr` is the entry with bits [s-1:0] cleared.
- R3: For an in-range lookup, `resp_mask` equals 2^s - 1.
- R4: `resp_perm` is entry bits [1:0]: 0 means no access, 1 read-only, 2 write-only, 3 read-write.
- R5: If the index (full bus address >> s) is at or beyond the effective entry count, the response is: permission 0, `resp_xaddr` 0, `resp_iova` 0, `resp_mask` all ones, and `resp_viol` 0.
- R6: `resp_viol` is 1 exactly when an in-range write request (`req_write`=1) meets permission 1, or a read request meets permission 2.
- R7: `resp_valid` rises on the clock edge after the edge at which `req_valid && req_ready`. It stays high with all response fields unchanged until `resp_ready` is sampled high. `req_ready` is low while a response is pending.
- R8: A `cfg_page_shift` below 12 acts as 12, and one above 24 acts as 24.
- R9: A `cfg_entries` above DEPTH acts as DEPTH.
- R10: A `tbl_wr_en` pulse stores `tbl_wr_data` at `tbl_wr_idx`. The write port is ignored during the post-reset sweep. A lookup accepted on the same edge as a write to the same index returns the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_page_shift | input | 5 | Page shift, clamped to 12..24 |
| cfg_entries | input | CNT_W | Number of valid table entries |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | IDX_W | Table write index |
| tbl_wr_data | input | ENTRY_W | Entry value to store |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_addr | input | ADDR_W | Bus address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response taken when high |
| resp_iova | output | ADDR_W | Page-aligned I/O address |
| resp_xaddr | output | ENTRY_W | Translated page base |
| resp_mask | output | ADDR_W | In-page offset mask |
| resp_perm | output | 2 | Permission code |
| resp_viol | output | 1 | Direction violation flag |

## Verification
Each lookup is accepted on one rising edge, and its response is due on the next edge. The bench drives inputs on falling edges and samples on the falling edge after the accept edge. There it checks that `resp_valid` is already high and compares every field against a bench-side model of the table. The post-reset sweep takes DEPTH cycles, so the bench waits for `req_ready` rather than counting cycles. A table write lands on the edge where it is sampled, so a lookup after it sees the new entry, while a lookup accepted on that same edge still sees the old one. A hold test keeps `resp_ready` low for several cycles and checks on each falling edge that the response fields do not move and that `req_ready` stays low.

// File: rtl/tce_pkg.sv
package tce_pkg;
    localparam int unsigned PS_MIN = 12;
    localparam int unsigned PS_MAX = 24;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_RESP  = 2'd2
    } tce_state_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } tce_perm_e;
endpackage

// File: rtl/tce_table_ram.sv
module tce_table_ram #(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned IDX_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port: indices past DEPTH are dropped
    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < DEPTH_L)) begin
            mem[waddr] <= wdata;
        end
    end

    // Read-first synchronous read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= ({1'b0, raddr} < DEPTH_L) ? mem[raddr] : '0;
        end
    end
endmodule

// File: rtl/tce_index_calc.sv
module tce_index_calc
    import tce_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [4:0]        shift_in,
    input  logic [CNT_W-1:0]  count_in,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output logic [ADDR_W-1:0] mask
);
    localparam logic [4:0]       SH_LO = 5'(PS_MIN);
    localparam logic [4:0]       SH_HI = 5'(PS_MAX);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [4:0]        shift_eff;
    logic [CNT_W-1:0]  count_eff;
    logic [ADDR_W-1:0] shifted;

    always_comb begin
        if (shift_in < SH_LO)      shift_eff = SH_LO;
        else if (shift_in > SH_HI) shift_eff = SH_HI;
        else                       shift_eff = shift_in;

        count_eff = (count_in > CNT_MAX) ? CNT_MAX : count_in;

        shifted  = addr >> shift_eff;
        idx      = shifted[IDX_W-1:0];
        in_range = (shifted < ADDR_W'(count_eff));
        mask     = (ADDR_W'(1) << shift_eff) - ADDR_W'(1);
    end
endmodule

// File: rtl/tce_lookup_fsm.sv
module tce_lookup_fsm
    import tce_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  calc_idx,
    input  logic              calc_in_range,
    input  logic [ADDR_W-1:0] calc_mask,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [ADDR_W-1:0] hold_addr,
    output logic              hold_write,
    output logic              hold_in_range,
    output logic [ADDR_W-1:0] hold_mask,
    output logic              clear_active,
    output logic [IDX_W-1:0]  clear_idx,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    tce_state_e state_q, state_d;
    logic       accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (clear_idx == LAST_IDX) state_d = ST_IDLE;  // T_CLEAR_DONE
            ST_IDLE:  if (req_valid)             state_d = ST_RESP;  // T_ACCEPT
            ST_RESP:  if (resp_ready)            state_d = ST_IDLE;  // T_RELEASE
            default:                             state_d = ST_CLEAR;
        endcase
    end

    // State register and held request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_CLEAR;
            clear_idx     <= '0;
            hold_addr     <= '0;
            hold_write    <= 1'b0;
            hold_in_range <= 1'b0;
            hold_mask     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) begin
                clear_idx <= clear_idx + IDX_W'(1);
            end
            if (accept) begin
                hold_addr     <= req_addr;
                hold_write    <= req_write;
                hold_in_range <= calc_in_range;
                hold_mask     <= calc_mask;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready    = 1'b0;
        resp_valid   = 1'b0;
        clear_active = 1'b0;
        unique case (state_q)
            ST_CLEAR: clear_active = 1'b1;
            ST_IDLE:  req_ready    = 1'b1;
            ST_RESP:  resp_valid   = 1'b1;
            default:  clear_active = 1'b0;
        endcase
        rd_en  = accept;
        rd_idx = calc_idx;
    end

    // R1: sweep must finish within DEPTH cycles of reset
    logic [IDX_W:0] clr_cycles;
    always_ff @(posedge clk) begin
        if (!rst_n)            clr_cycles <= '0;
        else if (clear_active) clr_cycles <= clr_cycles + 1'b1;
    end
    assert_sweep_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_active |-> (clr_cycles < (IDX_W+1)'(DEPTH)));
endmodule

// File: rtl/tce_resp_format.sv
module tce_resp_format
    import tce_pkg::*;
#(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned ENTRY_W = 64
) (
    input  logic [ADDR_W-1:0]  hold_addr,
    input  logic               hold_write,
    input  logic               hold_in_range,
    input  logic [ADDR_W-1:0]  hold_mask,
    input  logic [ENTRY_W-1:0] entry,
    output logic [ADDR_W-1:0]  iova,
    output logic [ENTRY_W-1:0] xaddr,
    output logic [ADDR_W-1:0]  mask,
    output logic [1:0]         perm,
    output logic               viol
);
    tce_perm_e code;

    always_comb begin
        code = tce_perm_e'(entry[1:0]);
        if (hold_in_range) begin
            iova  = hold_addr & ~hold_mask;
            xaddr = entry & ~ENTRY_W'(hold_mask);
            mask  = hold_mask;
            perm  = code;
            viol  = (hold_write && code == PERM_RD) ||
                    (!hold_write && code == PERM_WR);
        end else begin
            iova  = '0;
            xaddr = '0;
            mask  = '1;
            perm  = PERM_NONE;
            viol  = 1'b0;
        end
    end
endmodule

// File: rtl/tce_xlate.sv
module tce_xlate
    import tce_pkg::*;
#(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned ENTRY_W = 64,
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned IDX_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4:0]         cfg_page_shift,
    input  logic [CNT_W-1:0]   cfg_entries,
    input  logic               tbl_wr_en,
    input  logic [IDX_W-1:0]   tbl_wr_idx,
    input  logic [ENTRY_W-1:0] tbl_wr_data,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    output logic               resp_valid,
    input  logic               resp_ready,
    output logic [ADDR_W-1:0]  resp_iova,
    output logic [ENTRY_W-1:0] resp_xaddr,
    output logic [ADDR_W-1:0]  resp_mask,
    output logic [1:0]         resp_perm,
    output logic               resp_viol
);
    logic [IDX_W-1:0]   calc_idx;
    logic               calc_in_range;
    logic [ADDR_W-1:0]  calc_mask;
    logic [ADDR_W-1:0]  hold_addr;
    logic               hold_write;
    logic               hold_in_range;
    logic [ADDR_W-1:0]  hold_mask;
    logic               clear_active;
    logic [IDX_W-1:0]   clear_idx;
    logic               rd_en;
    logic [IDX_W-1:0]   rd_idx;
    logic [ENTRY_W-1:0] rd_data;
    logic               ram_we;
    logic [IDX_W-1:0]   ram_waddr;
    logic [ENTRY_W-1:0] ram_wdata;

    tce_index_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_calc (
        .addr     (req_addr),
        .shift_in (cfg_page_shift),
        .count_in (cfg_entries),
        .idx      (calc_idx),
        .in_range (calc_in_range),
        .mask     (calc_mask)
    );

    tce_lookup_fsm #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .calc_idx      (calc_idx),
        .calc_in_range (calc_in_range),
        .calc_mask     (calc_mask),
        .resp_valid    (resp_valid),
        .resp_ready    (resp_ready),
        .hold_addr     (hold_addr),
        .hold_write    (hold_write),
        .hold_in_range (hold_in_range),
        .hold_mask     (hold_mask),
        .clear_active  (clear_active),
        .clear_idx     (clear_idx),
        .rd_en         (rd_en),
        .rd_idx        (rd_idx)
    );

    // The sweep owns the write port until it ends
    always_comb begin
        if (clear_active) begin
            ram_we    = 1'b1;
            ram_waddr = clear_idx;
            ram_wdata = '0;
        end else begin
            ram_we    = tbl_wr_en;
            ram_waddr = tbl_wr_idx;
            ram_wdata = tbl_wr_data;
        end
    end

    tce_table_ram #(.DEPTH(DEPTH), .DATA_W(ENTRY_W), .IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (rd_en),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    tce_resp_format #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_fmt (
        .hold_addr     (hold_addr),
        .hold_write    (hold_write),
        .hold_in_range (hold_in_range),
        .hold_mask     (hold_mask),
        .entry         (rd_data),
        .iova          (resp_iova),
        .xaddr         (resp_xaddr),
        .mask          (resp_mask),
        .perm          (resp_perm),
        .viol          (resp_viol)
    );

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_iova) &&
            $stable(resp_xaddr) && $stable(resp_mask) && $stable(resp_perm) &&
            $stable(resp_viol)));

    assert_oor_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_mask == '1) |->
            (resp_xaddr == '0 && resp_iova == '0 && resp_perm == 2'd0 && !resp_viol));

    assert_viol_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_viol) |-> (resp_perm == 2'd1 || resp_perm == 2'd2));

    assert_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ((resp_iova & resp_mask) == '0 &&
                        (resp_xaddr & ENTRY_W'(resp_mask)) == '0));

    assert_mask_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_mask != '1) |-> ($countones(resp_mask + ADDR_W'(1)) == 1));
endmodule

// File: tb/tce_xlate_test.sv
`timescale 1ns/1ps
module tce_xlate_test;
    localparam int DEPTH = 64;
    localparam int IDX_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_page_shift = 5'd12;
    logic [15:0] cfg_entries = 16'd16;
    logic        tbl_wr_en = 1'b0;
    logic [IDX_W-1:0] tbl_wr_idx = '0;
    logic [63:0] tbl_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic [63:0] resp_iova, resp_xaddr, resp_mask;
    logic [1:0]  resp_perm;
    logic        resp_viol;

    always #2 clk = ~clk;

    tce_xlate #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_page_shift(cfg_page_shift), .cfg_entries(cfg_entries),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_iova(resp_iova),
        .resp_xaddr(resp_xaddr), .resp_mask(resp_mask), .resp_perm(resp_perm), .resp_viol(resp_viol)
    );

    typedef struct packed {
        logic [63:0] addr;
        logic        wr;
        logic [4:0]  shift;
        logic [15:0] cnt;
        logic [1:0]  eperm;
        logic        eviol;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{64'h0000_0000_0000_0123, 1'b0, 5'd12, 16'd16,  2'd0, 1'b0},
        '{64'h0000_0000_0000_1FFF, 1'b1, 5'd12, 16'd16,  2'd1, 1'b1},
        '{64'h0000_0000_0000_1456, 1'b0, 5'd12, 16'd16,  2'd1, 1'b0},
        '{64'h0000_0000_0000_2010, 1'b0, 5'd12, 16'd16,  2'd2, 1'b1},
        '{64'h0000_0000_0000_2010, 1'b1, 5'd12, 16'd16,  2'd2, 1'b0},
        '{64'h0000_0000_0000_3ABC, 1'b1, 5'd12, 16'd16,  2'd3, 1'b0},
        '{64'h0000_0000_0005_1234, 1'b0, 5'd16, 16'd8,   2'd1, 1'b0},
        '{64'h0000_0000_0008_0000, 1'b0, 5'd16, 16'd8,   2'd0, 1'b0},
        '{64'h000F_FFFF_0000_0000, 1'b1, 5'd12, 16'd16,  2'd0, 1'b0},
        '{64'h0000_0000_0000_4321, 1'b0, 5'd8,  16'd16,  2'd0, 1'b0},
        '{64'h0000_0000_0700_0001, 1'b1, 5'd30, 16'd16,  2'd3, 1'b0},
        '{64'h0000_0000_0003_F000, 1'b0, 5'd12, 16'd200, 2'd0, 1'b0},
        '{64'h0000_0000_0004_0000, 1'b0, 5'd12, 16'd200, 2'd0, 1'b0},
        '{64'h0000_0000_0000_0000, 1'b0, 5'd12, 16'd0,   2'd0, 1'b0}
    };

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [63:0] shadow [DEPTH];

    logic [63:0] g_iova, g_x, g_mask;
    logic [1:0]  g_perm;
    logic        g_viol, g_lat;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_of(input int i);
        return 64'h0000_00A5_0000_0000 | (64'(i) << 24) | 64'hAB0 | 64'(i % 4);
    endfunction

    task automatic tbl_write(input int idx, input logic [63:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = IDX_W'(idx); tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        shadow[idx] = d;
    endtask

    task automatic lookup(input logic [63:0] a, input logic w, input logic [4:0] s, input logic [15:0] c);
        @(negedge clk);
        cfg_page_shift = s; cfg_entries = c;
        req_addr = a; req_write = w; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        g_lat = resp_valid;
        g_iova = resp_iova; g_x = resp_xaddr; g_mask = resp_mask;
        g_perm = resp_perm; g_viol = resp_viol;
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
    endtask

    // Model of R2..R6, R8, R9 from the requirements
    task automatic expect_lookup(input string req, input logic [63:0] a, input logic w,
                                 input logic [4:0] s, input logic [15:0] c);
        int sh; int cn; logic [63:0] idx; logic in; logic [63:0] m, t, ei, ex; logic [1:0] p; logic v;
        sh = (s < 12) ? 12 : (s > 24) ? 24 : int'(s);
        cn = (c > DEPTH) ? DEPTH : int'(c);
        idx = a >> sh;
        in = (idx < 64'(cn));
        m  = in ? ((64'd1 << sh) - 1) : '1;
        t  = in ? shadow[idx[IDX_W-1:0]] : 64'd0;
        ei = in ? (a & ~m) : 64'd0;
        ex = in ? (t & ~m) : 64'd0;
        p  = t[1:0];
        v  = in && ((w && p == 2'd1) || (!w && p == 2'd2));
        chk({req, " R7"}, "resp_valid one cycle after accept", 64'(g_lat), 64'd1);
        chk({req, " R2/R5"}, "iova", g_iova, ei);
        chk({req, " R2/R5"}, "xaddr", g_x, ex);
        chk({req, " R3/R5"}, "mask", g_mask, m);
        chk({req, " R4"}, "perm", 64'(g_perm), 64'(p));
        chk({req, " R6"}, "viol", 64'(g_viol), 64'(v));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] h_iova, h_x;
        for (int i = 0; i < DEPTH; i++) shadow[i] = 64'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: ready held low during sweep
        chk("R1", "req_ready during sweep", 64'(req_ready), 64'd0);
        chk("R1", "resp_valid during sweep", 64'(resp_valid), 64'd0);
        // R10: write during sweep is ignored
        tbl_wr_en = 1'b1; tbl_wr_idx = 6'd9; tbl_wr_data = 64'hDEAD_BEEF_0000_0FF3;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        while (!req_ready) @(negedge clk);
        lookup(64'h9000, 1'b0, 5'd12, 16'd16);
        expect_lookup("R10 sweep-write-ignored R1", 64'h9000, 1'b0, 5'd12, 16'd16);

        for (int i = 0; i < 8; i++) tbl_write(i, entry_of(i));

        // Vector table: R2..R6, R8, R9
        for (int k = 0; k < NVEC; k++) begin
            lookup(VECS[k].addr, VECS[k].wr, VECS[k].shift, VECS[k].cnt);
            expect_lookup($sformatf("vec%0d", k), VECS[k].addr, VECS[k].wr, VECS[k].shift, VECS[k].cnt);
            chk($sformatf("vec%0d R4", k), "table perm", 64'(g_perm), 64'(VECS[k].eperm));
            chk($sformatf("vec%0d R6", k), "table viol", 64'(g_viol), 64'(VECS[k].eviol));
        end

        // R7: hold while resp_ready low
        @(negedge clk);
        cfg_page_shift = 5'd12; cfg_entries = 16'd16;
        req_addr = 64'h3123; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        h_iova = resp_iova; h_x = resp_xaddr;
        chk("R7", "resp_valid after accept", 64'(resp_valid), 64'd1);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R7", "resp_valid held", 64'(resp_valid), 64'd1);
            chk("R7", "req_ready low while pending", 64'(req_ready), 64'd0);
            chk("R7", "iova stable", resp_iova, h_iova);
            chk("R7", "xaddr stable", resp_xaddr, h_x);
        end
        chk("R7", "held xaddr value", h_x, entry_of(3) & ~64'hFFF);
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        chk("R7", "resp_valid drops after take", 64'(resp_valid), 64'd0);
        chk("R7", "req_ready back", 64'(req_ready), 64'd1);

        // R10: same-edge write and lookup of index 10 returns old entry
        @(negedge clk);
        cfg_page_shift = 5'd12; cfg_entries = 16'd16;
        req_addr = 64'hA000; req_write = 1'b1; req_valid = 1'b1;
        tbl_wr_en = 1'b1; tbl_wr_idx = 6'd10; tbl_wr_data = 64'h0000_0077_0000_0003;
        @(negedge clk);
        req_valid = 1'b0; tbl_wr_en = 1'b0;
        chk("R10", "same-edge read old xaddr", resp_xaddr, 64'd0);
        chk("R10", "same-edge read old perm", 64'(resp_perm), 64'd0);
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        shadow[10] = 64'h0000_0077_0000_0003;
        lookup(64'hA000, 1'b1, 5'd12, 16'd16);
        expect_lookup("R10 new entry", 64'hA000, 1'b1, 5'd12, 16'd16);

        // R1: second reset clears the table again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready low after re-reset", 64'(req_ready), 64'd0);
        for (int i = 0; i < DEPTH; i++) shadow[i] = 64'd0;
        while (!req_ready) @(negedge clk);
        lookup(64'h1000, 1'b1, 5'd12, 16'd16);
        expect_lookup("R1 cleared entry", 64'h1000, 1'b1, 5'd12, 16'd16);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule